// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a small serial slave that sets up an analog sensor front end. A host controller reaches it over three wires: an active-low chip select, a serial clock and one shared data line. The data line is split here into an input, an output and an output enable for the pad. Each transaction is 16 clocks long. It is made of an instruction byte and then a data byte. The instruction names a direction and a four-bit register address.

Three registers sit behind the interface:
- A device setup register. Its fields drive the front end's control pins: input choice, enables for the two amplifier stages, external filter routing, common-mode level and two gain codes.
- An 8-bit offset DAC code.
- A write-only key register.

Read-back stays off until two consecutive writes to the key register have placed a fixed two-byte pattern there. After that the slave drives the data line during the data byte of a read.

The serial clock clocks the logic directly. Chip select high works as an asynchronous transaction reset, so releasing it at any point abandons the transfer in progress. A separate power-on reset sets the register values.

Top module: `cfgspi_slave`

## Requirements
- R1: After power-on reset the device setup register is 0x00, so every decoded field is 0, and the DAC code is 0x80.
- R2: A completed write to address 0x0 sets the device setup register. The decoded fields are taken from the data byte as follows: bit 7 is input select, bit 6 is the first amplifier enable, bit 5 is the second amplifier enable, bit 4 is the external filter path, bit 3 is the common-mode select, bits 2:1 are the second-stage gain code and bit 0 is the first-stage gain select.
- R3: A completed write to address 0x1 loads the 8-bit DAC code. Nothing else changes it.
- R4: Bits are sampled on rising clock edges, MSB first. The instruction byte comes first and the data byte second. A write takes effect only on the 16th rising edge of a transaction that chip select has not interrupted. Raising chip select earlier changes nothing, and the next assertion of chip select starts a new instruction byte.
- R5: Writing 0xFE and then 0xED to address 0xF, in consecutive completed writes to that address, enables read mode. A 0xFE write always arms the sequence.
- R6: Any other completed write to address 0xF disarms the sequence and leaves read mode. While read mode is off, a read never drives the data line.
- R7: A read of address 0x0 or 0x1 in read mode works as follows. The slave drives the line from the falling edge that follows the 8th rising edge. It changes the bit on each falling edge and sends the register MSB first. It releases the line after the 16th rising edge, or at once when chip select rises.
- R8: Instruction bit 7 gives the direction: 0 is a write, 1 is a read. Bits 6:4 must be zero and bits 3:0 hold the address. An instruction with a nonzero bit in 6:4, or with an address other than 0x0, 0x1 or 0xF, is ignored. A read of 0xF is ignored as well. Ignored means no register changes and the line is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Asynchronous power-on reset, active low |
| csn | input | 1 | Chip select, active low; high clears the transaction |
| sclk | input | 1 | Serial clock |
| sdio_in | input | 1 | Data line as seen by the slave |
| sdio_out | output | 1 | Read data driven onto the data line |
| sdio_oe | output | 1 | Output enable for the data line pad |
| in_sel | output | 1 | Sensor input select |
| amp_en | output | 2 | Amplifier enables, [1] first stage, [0] second stage |
| ext_path | output | 1 | Route the stages through the external filter |
| cm_hi | output | 1 | Select the higher common-mode level |
| pga2_gain | output | 2 | Second-stage gain code |
| pga1_low | output | 1 | Select the low first-stage gain |
| dac_code | output | 8 | Offset DAC code |

## Verification
The bench writes all 256 codes to both writable registers and compares every decoded port with the code it wrote. A wrong field order or a shifted bit would show as a mismatch on some code. It breaks off a write after each count from 1 to 15 rising edges; a design that commits early, or that keeps a stale bit count across chip select, would change the DAC code or lose the next full write. It runs the unlock pattern with a foreign byte in between, with repeated 0xFE bytes, with a broken-off second byte and with the exit write; a tracker that skips the consecutive rule or never leaves read mode would drive the line where it must stay released. Read timing is checked at every data bit and just after the 16th edge and after chip select rises, so a drive that starts one clock off or never releases the line is caught.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;

  // Byte width of both instruction and data fields; the frame is two of them.
  parameter int unsigned WORD_W = 8;
  localparam int unsigned FRAME_BITS = 2 * WORD_W;
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);
  localparam int unsigned IDX_W = $clog2(WORD_W);
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_DEV = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_DAC = 4'h1;
  localparam logic [ADDR_W-1:0] ADDR_KEY = 4'hF;

  localparam logic [WORD_W-1:0] KEY_FIRST  = 8'hFE;
  localparam logic [WORD_W-1:0] KEY_SECOND = 8'hED;
  localparam logic [WORD_W-1:0] DAC_RESET  = 8'h80;

  // Field order is fixed by the front-end pin decode, MSB first.
  typedef struct packed {
    logic       in_sel;
    logic [1:0] amp_en;
    logic       ext_path;
    logic       cm_hi;
    logic [1:0] pga2_gain;
    logic       pga1_low;
  } dev_cfg_t;

  typedef enum logic { UNL_IDLE, UNL_ARMED } unl_t;

  function automatic logic [ADDR_W-1:0] instr_addr(input logic [WORD_W-1:0] ins);
    return ins[ADDR_W-1:0];
  endfunction

  function automatic logic instr_fmt_ok(input logic [WORD_W-1:0] ins);
    logic [ADDR_W-1:0] a;
    a = instr_addr(ins);
    return (ins[WORD_W-2:ADDR_W] == '0) &&
           (a == ADDR_DEV || a == ADDR_DAC || a == ADDR_KEY);
  endfunction

  function automatic logic instr_is_write(input logic [WORD_W-1:0] ins);
    return !ins[WORD_W-1];
  endfunction

  function automatic logic instr_may_read(input logic [WORD_W-1:0] ins,
                                          input logic rd_mode);
    return ins[WORD_W-1] && instr_fmt_ok(ins) &&
           (instr_addr(ins) != ADDR_KEY) && rd_mode;
  endfunction

  // Bit of the read word to present while bit_cnt edges have been seen.
  function automatic logic [IDX_W-1:0] tx_bit_index(input logic [CNT_W-1:0] cnt);
    logic [CNT_W-1:0] r;
    r = CNT_W'(FRAME_BITS - 1) - cnt;
    return r[IDX_W-1:0];
  endfunction

endpackage

// File: rtl/cfgspi_frame.sv
module cfgspi_frame
  import cfgspi_pkg::*;
(
  input  logic              sclk,
  input  logic              csn,
  input  logic              por_n,
  input  logic              sdi,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [WORD_W-1:0] instr,
  output logic [WORD_W-1:0] wdata,
  output logic              wr_commit
);

  logic              xact_rst;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] next_word;

  assign xact_rst  = csn | ~por_n;
  assign next_word = {shreg[WORD_W-2:0], sdi};

  always_ff @(posedge sclk or posedge xact_rst) begin
    if (xact_rst) begin
      bit_cnt <= '0;
      shreg   <= '0;
      instr   <= '0;
    end else begin
      shreg <= next_word;
      if (bit_cnt != CNT_W'(FRAME_BITS)) bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == CNT_W'(WORD_W - 1)) instr <= next_word;
    end
  end

  assign wdata     = next_word;
  assign wr_commit = (bit_cnt == CNT_W'(FRAME_BITS - 1)) &&
                     instr_is_write(instr) && instr_fmt_ok(instr);

  // R4
  cnt_cap_chk: assert property (@(posedge sclk) disable iff (xact_rst)
    bit_cnt <= CNT_W'(FRAME_BITS));

  // R4
  no_recommit_chk: assert property (@(posedge sclk) disable iff (xact_rst)
    (bit_cnt == CNT_W'(FRAME_BITS)) |-> !wr_commit);

endmodule

// File: rtl/cfgspi_regs.sv
module cfgspi_regs
  import cfgspi_pkg::*;
(
  input  logic              sclk,
  input  logic              por_n,
  input  logic              wr_commit,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  output dev_cfg_t          dev_cfg,
  output logic [WORD_W-1:0] dac_code,
  output logic              rd_mode
);

  unl_t unl_q;
  logic key_wr;

  assign key_wr = wr_commit && (waddr == ADDR_KEY);

  always_ff @(posedge sclk or negedge por_n) begin
    if (!por_n) begin
      dev_cfg  <= '0;
      dac_code <= DAC_RESET;
      rd_mode  <= 1'b0;
      unl_q    <= UNL_IDLE;
    end else if (wr_commit) begin
      case (waddr)
        ADDR_DEV: dev_cfg  <= dev_cfg_t'(wdata);
        ADDR_DAC: dac_code <= wdata;
        ADDR_KEY: begin
          if (wdata == KEY_FIRST) begin
            unl_q   <= UNL_ARMED;
            rd_mode <= 1'b0;
          end else if (unl_q == UNL_ARMED && wdata == KEY_SECOND) begin
            unl_q   <= UNL_IDLE;
            rd_mode <= 1'b1;
          end else begin
            unl_q   <= UNL_IDLE;
            rd_mode <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  // R3
  dac_hold_chk: assert property (@(posedge sclk) disable iff (!por_n)
    !wr_commit |=> $stable(dac_code));

  // R2
  cfg_hold_chk: assert property (@(posedge sclk) disable iff (!por_n)
    !(wr_commit && waddr == ADDR_DEV) |=> $stable(dev_cfg));

  // R5
  unlock_cause_chk: assert property (@(posedge sclk) disable iff (!por_n)
    $rose(rd_mode) |-> $past(key_wr && wdata == KEY_SECOND));

  // R6
  lock_exit_chk: assert property (@(posedge sclk) disable iff (!por_n)
    (key_wr && wdata != KEY_SECOND) |=> !rd_mode);

endmodule

// File: rtl/cfgspi_txout.sv
module cfgspi_txout
  import cfgspi_pkg::*;
(
  input  logic              sclk,
  input  logic              csn,
  input  logic              por_n,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [WORD_W-1:0] instr,
  input  logic              rd_mode,
  input  dev_cfg_t          dev_cfg,
  input  logic [WORD_W-1:0] dac_code,
  output logic              sdio_out,
  output logic              sdio_oe
);

  logic              xact_rst;
  logic              in_data_phase;
  logic              rd_ok;
  logic [WORD_W-1:0] rd_word;
  logic              oe_q;

  assign xact_rst      = csn | ~por_n;
  assign in_data_phase = (bit_cnt >= CNT_W'(WORD_W)) && (bit_cnt < CNT_W'(FRAME_BITS));
  assign rd_ok         = instr_may_read(instr, rd_mode);
  assign rd_word       = (instr_addr(instr) == ADDR_DAC) ? dac_code : WORD_W'(dev_cfg);

  always_ff @(negedge sclk or posedge xact_rst) begin
    if (xact_rst) begin
      oe_q     <= 1'b0;
      sdio_out <= 1'b0;
    end else if (in_data_phase && rd_ok) begin
      oe_q     <= 1'b1;
      sdio_out <= rd_word[tx_bit_index(bit_cnt)];
    end else begin
      oe_q     <= 1'b0;
      sdio_out <= 1'b0;
    end
  end

  // Released as soon as the 16th rising edge has been counted.
  assign sdio_oe = oe_q && (bit_cnt != CNT_W'(FRAME_BITS));

  // R7
  drive_window_chk: assert property (@(posedge sclk) disable iff (xact_rst)
    sdio_oe |-> (bit_cnt >= CNT_W'(WORD_W) && bit_cnt < CNT_W'(FRAME_BITS)));

  // R6
  drive_needs_mode_chk: assert property (@(posedge sclk) disable iff (xact_rst)
    sdio_oe |-> rd_mode);

  // R8
  drive_fmt_chk: assert property (@(posedge sclk) disable iff (xact_rst)
    sdio_oe |-> (instr[WORD_W-2:ADDR_W] == '0 && instr_addr(instr) != ADDR_KEY));

endmodule

// File: rtl/cfgspi_slave.sv
module cfgspi_slave
  import cfgspi_pkg::*;
(
  input  logic        por_n,
  input  logic        csn,
  input  logic        sclk,
  input  logic        sdio_in,
  output logic        sdio_out,
  output logic        sdio_oe,
  output logic        in_sel,
  output logic [1:0]  amp_en,
  output logic        ext_path,
  output logic        cm_hi,
  output logic [1:0]  pga2_gain,
  output logic        pga1_low,
  output logic [7:0]  dac_code
);

  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] instr;
  logic [WORD_W-1:0] wdata;
  logic              wr_commit;
  logic              rd_mode;
  dev_cfg_t          dev_cfg;

  cfgspi_frame frame_i (
    .sclk      (sclk),
    .csn       (csn),
    .por_n     (por_n),
    .sdi       (sdio_in),
    .bit_cnt   (bit_cnt),
    .instr     (instr),
    .wdata     (wdata),
    .wr_commit (wr_commit)
  );

  cfgspi_regs regs_i (
    .sclk      (sclk),
    .por_n     (por_n),
    .wr_commit (wr_commit),
    .waddr     (instr_addr(instr)),
    .wdata     (wdata),
    .dev_cfg   (dev_cfg),
    .dac_code  (dac_code),
    .rd_mode   (rd_mode)
  );

  cfgspi_txout txout_i (
    .sclk      (sclk),
    .csn       (csn),
    .por_n     (por_n),
    .bit_cnt   (bit_cnt),
    .instr     (instr),
    .rd_mode   (rd_mode),
    .dev_cfg   (dev_cfg),
    .dac_code  (dac_code),
    .sdio_out  (sdio_out),
    .sdio_oe   (sdio_oe)
  );

  assign in_sel    = dev_cfg.in_sel;
  assign amp_en    = dev_cfg.amp_en;
  assign ext_path  = dev_cfg.ext_path;
  assign cm_hi     = dev_cfg.cm_hi;
  assign pga2_gain = dev_cfg.pga2_gain;
  assign pga1_low  = dev_cfg.pga1_low;

endmodule

// File: tb/cfgspi_slave_tb_top.sv
module cfgspi_slave_tb_top;

  logic       sclk = 1'b0;
  logic       por_n = 1'b0;
  logic       csn = 1'b1;
  logic       sdio_in = 1'b0;
  logic       sdio_out, sdio_oe;
  logic       in_sel, ext_path, cm_hi, pga1_low;
  logic [1:0] amp_en, pga2_gain;
  logic [7:0] dac_code;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Results of the last transfer
  logic [7:0] r_data;
  int         r_oe_cnt;
  bit         r_early;
  bit         r_tail_oe;
  bit         r_after_cs;

  always #4 sclk = ~sclk;

  cfgspi_slave dut_i (
    .por_n(por_n), .csn(csn), .sclk(sclk), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .in_sel(in_sel), .amp_en(amp_en),
    .ext_path(ext_path), .cm_hi(cm_hi), .pga2_gain(pga2_gain),
    .pga1_low(pga1_low), .dac_code(dac_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int cfg_ports();
    return (int'(in_sel) << 7) + (int'(amp_en[1]) << 6) + (int'(amp_en[0]) << 5) +
           (int'(ext_path) << 4) + (int'(cm_hi) << 3) + (int'(pga2_gain) << 1) +
           int'(pga1_low);
  endfunction

  // One transaction of nbits clocks; inputs change only on falling edges.
  task automatic xfer(input logic [7:0] ins, input logic [7:0] dat, input int nbits);
    logic [15:0] word;
    word = {ins, dat};
    r_data = 8'h00; r_oe_cnt = 0; r_early = 0;
    @(negedge sclk);
    csn = 1'b0;
    for (int k = 0; k < nbits; k++) begin
      if (k > 0) @(negedge sclk);
      sdio_in = word[15-k];
      #1;
      if (k >= 8) begin
        if (sdio_oe === 1'b1) begin
          r_oe_cnt++;
          r_data[15-k] = sdio_out;
        end
      end else if (sdio_oe !== 1'b0) r_early = 1;
    end
    @(negedge sclk);
    #1;
    r_tail_oe = (sdio_oe === 1'b1);
    csn = 1'b1;
    #1;
    r_after_cs = (sdio_oe === 1'b1);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    xfer({4'h0, a}, d, 16);
  endtask

  task automatic rd(input logic [3:0] a);
    xfer({4'h8, a}, 8'h00, 16);
  endtask

  task automatic expect_no_drive(input string req);
    check(r_oe_cnt == 0 && !r_early && !r_tail_oe, req, r_oe_cnt, 0);
  endtask

  task automatic expect_read(input string req, input int exp);
    check(r_oe_cnt == 8 && !r_early, {req, " drive window"}, r_oe_cnt, 8);
    check(int'(r_data) == exp, {req, " data"}, r_data, exp);
    check(!r_tail_oe, {req, " release after 16th"}, r_tail_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge sclk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int dac_exp;
    int cfg_exp;
    repeat (3) @(negedge sclk);
    por_n = 1'b1;
    @(negedge sclk); #1;

    // R1 reset values
    check(cfg_ports() == 0, "R1 setup reset", cfg_ports(), 0);
    check(dac_code == 8'h80, "R1 dac reset", dac_code, 8'h80);

    // R6 locked: no drive
    rd(4'h1); expect_no_drive("R6 read while locked");

    // R2 sweep of the setup register
    for (int v = 0; v < 256; v++) begin
      wr(4'h0, 8'(v));
      check(cfg_ports() == v, "R2 field decode", cfg_ports(), v);
    end
    cfg_exp = 255;

    // R3 sweep of the DAC code
    for (int v = 0; v < 256; v++) begin
      wr(4'h1, 8'(v));
      check(int'(dac_code) == v, "R3 dac write", dac_code, v);
      check(cfg_ports() == cfg_exp, "R3 setup untouched", cfg_ports(), cfg_exp);
    end

    // R4 interrupted writes commit nothing
    wr(4'h1, 8'h3C); dac_exp = 8'h3C;
    for (int n = 1; n < 16; n++) begin
      xfer(8'h01, 8'hA5, n);
      check(int'(dac_code) == dac_exp, "R4 abort", dac_code, dac_exp);
    end
    wr(4'h1, 8'h5A); dac_exp = 8'h5A;
    check(int'(dac_code) == dac_exp, "R4 fresh frame", dac_code, dac_exp);

    // R8 prohibited bits and unknown addresses
    for (int b = 1; b < 8; b++) begin
      xfer({1'b0, 3'(b), 4'h1}, 8'h77, 16);
      check(int'(dac_code) == dac_exp, "R8 reserved bits", dac_code, dac_exp);
      xfer({1'b0, 3'(b), 4'h0}, 8'h11, 16);
      check(cfg_ports() == cfg_exp, "R8 reserved bits setup", cfg_ports(), cfg_exp);
    end
    for (int a = 2; a < 15; a++) begin
      wr(4'(a), 8'h00);
      check(int'(dac_code) == dac_exp && cfg_ports() == cfg_exp, "R8 unknown address",
            dac_code, dac_exp);
    end

    // R5 unlock and R7 reads
    wr(4'hF, 8'hFE); wr(4'hF, 8'hED);
    rd(4'h0); expect_read("R5 R7 read setup", cfg_exp);
    rd(4'h1); expect_read("R7 read dac", dac_exp);
    for (int v = 0; v < 256; v += 37) begin
      wr(4'h1, 8'(v));
      rd(4'h1); expect_read("R7 read sweep", v);
      wr(4'h0, 8'(255 - v));
      rd(4'h0); expect_read("R7 read setup sweep", 255 - v);
    end
    cfg_exp = 255 - 222;

    // R8 ignored reads in read mode
    xfer(8'h91, 8'h00, 16); expect_no_drive("R8 read reserved bits");
    rd(4'hF); expect_no_drive("R8 read key register");
    rd(4'h3); expect_no_drive("R8 read unknown address");

    // R7 release on chip select mid-read
    xfer(8'h80, 8'h00, 12);
    check(r_tail_oe && !r_after_cs, "R7 release on csn", r_after_cs, 0);
    check(r_oe_cnt == 4, "R7 partial drive", r_oe_cnt, 4);

    // R6 exit write
    wr(4'hF, 8'h00);
    rd(4'h1); expect_no_drive("R6 exit write");

    // R6 foreign byte between key bytes
    wr(4'hF, 8'hFE); wr(4'hF, 8'h12); wr(4'hF, 8'hED);
    rd(4'h1); expect_no_drive("R6 broken sequence");

    // R5 repeated first byte still arms
    wr(4'hF, 8'hFE); wr(4'hF, 8'hFE); wr(4'hF, 8'hED);
    rd(4'h0); expect_read("R5 repeated first byte", cfg_exp);

    // R6 second key byte alone leaves read mode
    wr(4'hF, 8'hED);
    rd(4'h0); expect_no_drive("R6 lone second byte");

    // R4 R5 interrupted second key byte does not unlock
    wr(4'hF, 8'hFE); xfer(8'h0F, 8'hED, 15);
    rd(4'h0); expect_no_drive("R4 R5 aborted key byte");
    check(cfg_ports() == cfg_exp, "R2 setup held", cfg_ports(), cfg_exp);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule